// File: doc/BRIEF.md
# Serial Programming Link Synchroniser

This block sits on the host side of a three-wire synchronous serial link (clock, host-to-target data, target-to-host data) plus a reset line to the target. On a start request it puts the link lines in their power-up state, optionally pulses the target reset after the clock line is known to be low, waits a settling interval and then sends the four-byte programming-enable frame. The byte the target returns while the third byte is going out must equal the second byte sent. If it does, the link is in step and the block finishes with success.

When the readback is wrong, the block still finishes the frame. It then gives the clock one extra positive pulse, which moves the target's bit framing by one position, and sends the whole frame again. After a fixed number of attempts without a correct echo, the block finishes and reports that no target is attached. A parent controller sees one `done` pulse together with a held `synced` status bit.

Top module: `prog_link_sync`

## Requirements
- R1: After reset, `sck`, `mosi`, `tgt_rst`, `done` and `synced` are all 0.
- R2: Each high phase and each low phase of `sck` lasts exactly `sck_half` system clocks. The value is latched at start and must be at least 2.
- R3: Each frame is 32 bits sent most significant bit first. The bytes are 0xAC, 0x53, 0x00, 0x00 (first, third and fourth set by parameter). `mosi` does not change while `sck` is high.
- R4: With `pulse_rst`=1 at start, `tgt_rst` is high for exactly `sck_half` clocks while `sck` is low, and only after `sck` has been low for `sck_half` clocks. With `pulse_rst`=0, `tgt_rst` stays 0.
- R5: No rising edge of `sck` occurs until at least SETTLE_CYC + `sck_half` clocks after start.
- R6: `miso` is sampled on the clock where `sck` rises. The readback from frame bits 16 to 23 (0-based, counted from the first bit sent) is compared with 0x53. A match ends the attempt with `synced`=1. A successful attempt n therefore produces 33n-1 rising edges of `sck` in total.
- R7: All 32 bits of a frame are clocked out even when the attempt is going to fail.
- R8: After a failed frame, `sck` gets exactly one extra positive pulse, made of a low phase and then a high phase, before the next frame starts.
- R9: After MAX_TRIES (32) failed frames, the block ends with `synced`=0, having produced 33*32-1 = 1055 rising edges of `sck`.
- R10: `done` is high for exactly one clock per run. `synced` holds its value until the next start.
- R11: `start` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a link bring-up run (taken only when idle) |
| pulse_rst | input | 1 | Give the target reset a positive pulse after the clock line is low |
| sck_half | input | HALF_W | System clocks per serial clock phase, at least 2 |
| miso | input | 1 | Serial data from target |
| sck | output | 1 | Serial clock to target |
| mosi | output | 1 | Serial data to target |
| tgt_rst | output | 1 | Target reset line |
| done | output | 1 | One-cycle end-of-run pulse |
| synced | output | 1 | 1 = echo confirmed, 0 = no target found |

## Verification
The assertions assume that `sck_half` is at least 2 whenever a phase timer runs. They also assume that `miso` settles within one serial phase of a falling clock edge, so that it is stable at the next rising edge. The bench sets `sck_half` only from 2 to 5 and holds it steady through each run. Its target model changes `miso` only on falling `sck` edges, and a misaligned target drives zeros, so the sampled data is never ambiguous. Reset pulses from the block realign the model's byte framing, which shows that the pulse reaches the target.

// File: rtl/pls_pkg.sv
package pls_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PWR,
      ST_RSTP,
      ST_WAIT,
      ST_SHIFT,
      ST_RSLO,
      ST_RSHI,
      ST_DONE
   } pls_state_t;
endpackage

// File: rtl/pls_phase_timer.sv
module pls_phase_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic [W-1:0] limit,
   output logic         tick
);
   logic [W-1:0] cnt;

   assign tick = run && (cnt == limit - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (!run)   cnt <= '0;
      else if (tick)   cnt <= '0;
      else             cnt <= cnt + W'(1);
   end

   // R2: a phase shorter than two clocks is outside the supported range
   a_r2_limit_min: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (limit >= W'(2)));

   a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt < limit));
endmodule

// File: rtl/pls_frame_shifter.sv
module pls_frame_shifter #(
   parameter int          BW        = 8,
   parameter int          NBYTES    = 4,
   parameter int          ECHO_SLOT = 2,
   parameter logic [7:0]  ECHO_VAL  = 8'h53,
   parameter logic [31:0] FRAME     = 32'hAC53_0000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic cap,
   input  logic adv,
   input  logic miso,
   output logic mosi_bit,
   output logic last,
   output logic echo_ok
);
   localparam int FRAME_W   = BW * NBYTES;
   localparam int IDXW      = $clog2(FRAME_W);
   localparam int ECHO_LAST = (ECHO_SLOT + 1) * BW - 1;

   logic [FRAME_W-1:0] tx;
   logic [BW-1:0]      rx;
   logic [IDXW-1:0]    bidx;
   logic [BW-1:0]      rx_nxt;

   generate
      if (FRAME_W != 32) begin : g_bad_frame
         $error("frame width must be 32 bits");
      end
      if (ECHO_SLOT >= NBYTES) begin : g_bad_slot
         $error("echo slot outside frame");
      end
   endgenerate

   assign rx_nxt   = {rx[BW-2:0], miso};
   assign mosi_bit = tx[FRAME_W-1];
   assign last     = (bidx == IDXW'(FRAME_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx      <= '0;
         rx      <= '0;
         bidx    <= '0;
         echo_ok <= 1'b0;
      end else if (load) begin
         tx      <= FRAME[FRAME_W-1:0];
         bidx    <= '0;
         echo_ok <= 1'b0;
      end else begin
         if (cap) begin
            rx <= rx_nxt;
            if (bidx == IDXW'(ECHO_LAST))
               echo_ok <= (rx_nxt == ECHO_VAL[BW-1:0]);
         end
         if (adv) begin
            tx   <= {tx[FRAME_W-2:0], 1'b0};
            bidx <= bidx + IDXW'(1);
         end
      end
   end

   // R6: the echo flag only rises right after a capture
   a_r6_echo_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(echo_ok) |-> $past(cap));

   // R7: capture and advance never coincide
   a_r7_cap_adv_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cap && adv));
endmodule

// File: rtl/pls_retry_ctr.sv
module pls_retry_ctr #(
   parameter int MAX_TRIES = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic exhausted
);
   localparam int TW = (MAX_TRIES < 2) ? 1 : $clog2(MAX_TRIES);

   logic [TW-1:0] tries;

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (MAX_TRIES == 1) begin : g_single
         assign exhausted = 1'b1;
      end else begin : g_multi
         assign exhausted = (tries == TW'(MAX_TRIES - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tries <= '0;
      else if (clr) tries <= '0;
      else if (inc) tries <= tries + TW'(1);
   end

   // R9: never count past the last permitted attempt
   a_r9_tries_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tries) <= MAX_TRIES - 1);

   a_r9_no_inc_when_spent: assert property (@(posedge clk) disable iff (!rst_n)
      exhausted |-> !inc);
endmodule

// File: rtl/prog_link_sync.sv
module prog_link_sync #(
   parameter int         HALF_W     = 8,
   parameter int         SETTLE_CYC = 4_000_000,
   parameter int         MAX_TRIES  = 32,
   parameter logic [7:0] EN_B0      = 8'hAC,
   parameter logic [7:0] EN_B2      = 8'h00,
   parameter logic [7:0] EN_B3      = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              pulse_rst,
   input  logic [HALF_W-1:0] sck_half,
   input  logic              miso,
   output logic              sck,
   output logic              mosi,
   output logic              tgt_rst,
   output logic              done,
   output logic              synced
);
   import pls_pkg::*;

   localparam logic [7:0]  SYNC_BYTE = 8'h53;
   localparam logic [31:0] FRAME     = {EN_B0, SYNC_BYTE, EN_B2, EN_B3};
   localparam int          SW        = $clog2(SETTLE_CYC + 1);

   generate
      if (HALF_W < 2) begin : g_bad_halfw
         $error("HALF_W must be at least 2");
      end
      if (SETTLE_CYC < 2) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 2");
      end
   endgenerate

   pls_state_t        st;
   logic              hi;
   logic              pulse_q;
   logic              synced_q;
   logic [HALF_W-1:0] half_q;

   logic ph_run, ph_tick, set_run, set_tick;
   logic ld, cap, adv, mosi_bit, last, echo_ok;
   logic try_clr, try_inc, exhausted;

   assign ph_run  = (st == ST_PWR) || (st == ST_RSTP) || (st == ST_SHIFT) ||
                    (st == ST_RSLO) || (st == ST_RSHI);
   assign set_run = (st == ST_WAIT);

   assign ld  = (set_run && set_tick) || ((st == ST_RSHI) && ph_tick);
   assign cap = (st == ST_SHIFT) && !hi && ph_tick;
   assign adv = (st == ST_SHIFT) && hi && ph_tick && !last;

   assign try_clr = (st == ST_IDLE) && start;
   assign try_inc = (st == ST_SHIFT) && hi && ph_tick && last && !echo_ok && !exhausted;

   pls_phase_timer #(.W(HALF_W)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (ph_run),
      .limit (half_q),
      .tick  (ph_tick)
   );

   pls_phase_timer #(.W(SW)) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (set_run),
      .limit (SW'(SETTLE_CYC)),
      .tick  (set_tick)
   );

   pls_frame_shifter #(
      .BW        (8),
      .NBYTES    (4),
      .ECHO_SLOT (2),
      .ECHO_VAL  (SYNC_BYTE),
      .FRAME     (FRAME)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .cap      (cap),
      .adv      (adv),
      .miso     (miso),
      .mosi_bit (mosi_bit),
      .last     (last),
      .echo_ok  (echo_ok)
   );

   pls_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (try_clr),
      .inc       (try_inc),
      .exhausted (exhausted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         hi       <= 1'b0;
         pulse_q  <= 1'b0;
         synced_q <= 1'b0;
         half_q   <= HALF_W'(2);
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               half_q   <= sck_half;
               pulse_q  <= pulse_rst;
               synced_q <= 1'b0;
               st       <= ST_PWR;
            end
            ST_PWR:  if (ph_tick) st <= pulse_q ? ST_RSTP : ST_WAIT;
            ST_RSTP: if (ph_tick) st <= ST_WAIT;
            ST_WAIT: if (set_tick) begin
               st <= ST_SHIFT;
               hi <= 1'b0;
            end
            ST_SHIFT: if (ph_tick) begin
               if (!hi) begin
                  hi <= 1'b1;
               end else begin
                  hi <= 1'b0;
                  if (last) begin
                     if (echo_ok) begin
                        synced_q <= 1'b1;
                        st       <= ST_DONE;
                     end else if (exhausted) begin
                        synced_q <= 1'b0;
                        st       <= ST_DONE;
                     end else begin
                        st <= ST_RSLO;
                     end
                  end
               end
            end
            ST_RSLO: if (ph_tick) st <= ST_RSHI;
            ST_RSHI: if (ph_tick) begin
               st <= ST_SHIFT;
               hi <= 1'b0;
            end
            ST_DONE: st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign sck     = ((st == ST_SHIFT) && hi) || (st == ST_RSHI);
   assign mosi    = (st == ST_SHIFT) ? mosi_bit : 1'b0;
   assign tgt_rst = (st == ST_RSTP);
   assign done    = (st == ST_DONE);
   assign synced  = synced_q;

   // R3: data to the target is steady for the whole high phase
   a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R4: the reset pulse only happens with the clock line low
   a_r4_rst_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rst |-> !sck);

   // R10: completion is a single-cycle pulse
   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10: status is steady in the cycle after completion
   a_r10_synced_hold: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(synced));

   // R11: a start request while busy does not restart the power-up phase
   a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (st != ST_IDLE) && (st != ST_DONE)) |=> (st != ST_PWR));
endmodule

// File: tb/sim_prog_link_sync.sv
`timescale 1ns/1ps
module sim_prog_link_sync;
   localparam int SETTLE_B = 40;

   // stim: pulse, half[3:0], p0[2:0], present ; exp: synced, edges[11:0]
   localparam logic [21:0] VEC [7] = '{
      {1'b0, 4'd2, 3'd0, 1'b1, 1'b1, 12'd32},
      {1'b0, 4'd3, 3'd5, 1'b1, 1'b1, 12'd131},
      {1'b0, 4'd2, 3'd1, 1'b1, 1'b1, 12'd263},
      {1'b1, 4'd2, 3'd3, 1'b1, 1'b1, 12'd32},
      {1'b0, 4'd2, 3'd0, 1'b0, 1'b0, 12'd1055},
      {1'b1, 4'd4, 3'd6, 1'b0, 1'b0, 12'd1055},
      {1'b0, 4'd5, 3'd7, 1'b1, 1'b1, 12'd65}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic pulse_rst = 1'b0;
   logic [7:0] sck_half = 8'd2;
   logic miso;
   logic sck, mosi, tgt_rst, done, synced;

   always #2.5 clk = ~clk;

   prog_link_sync #(.SETTLE_CYC(SETTLE_B)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pulse_rst(pulse_rst),
      .sck_half(sck_half), .miso(miso), .sck(sck), .mosi(mosi),
      .tgt_rst(tgt_rst), .done(done), .synced(synced)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // target model and monitor
   logic clr = 1'b0;
   int   cfg_p0 = 0;
   logic cfg_present = 1'b0;
   int   cyc, nrise, first_rise, hiw, rstc, donec, mcnt;
   logic [31:0] frame;
   logic [7:0]  rxb, ldv, txs;
   logic armed, ld, miso_r, prev;

   assign miso = cfg_present ? miso_r : 1'b0;

   always @(negedge clk) begin
      if (clr) begin
         cyc = 0; nrise = 0; first_rise = 0; hiw = 0; rstc = 0; donec = 0;
         mcnt = cfg_p0; frame = '0; rxb = '0; ldv = '0; txs = '0;
         armed = 1'b0; ld = 1'b0; miso_r = 1'b0; prev = 1'b0;
      end else begin
         cyc = cyc + 1;
         if (tgt_rst) begin
            mcnt = 0; armed = 1'b0; ld = 1'b0; txs = '0; rstc = rstc + 1;
         end
         if (sck && !prev) begin
            nrise = nrise + 1;
            if (nrise <= 32) frame = {frame[30:0], mosi};
            if (first_rise == 0) first_rise = cyc;
            rxb  = {rxb[6:0], mosi};
            mcnt = (mcnt + 1) % 8;
            if (mcnt == 0) begin
               ldv   = armed ? rxb : 8'h00;
               ld    = 1'b1;
               armed = (rxb == 8'hAC);
            end
         end
         if (!sck && prev) begin
            if (ld) begin
               miso_r = ldv[7]; txs = {ldv[6:0], 1'b0}; ld = 1'b0;
            end else begin
               miso_r = txs[7]; txs = {txs[6:0], 1'b0};
            end
         end
         if (sck && nrise == 1) hiw = hiw + 1;
         if (done) donec = donec + 1;
         prev = sck;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_vec(input logic p, input int half, input int p0,
                          input logic pres, input logic exp_s, input int exp_e,
                          input bit poke);
      @(posedge clk); #1;
      cfg_p0 = p0; cfg_present = pres; clr = 1'b1;
      @(posedge clk); #1;
      clr = 1'b0; start = 1'b1; pulse_rst = p; sck_half = 8'(half);
      @(posedge clk); #1;
      start = 1'b0;
      for (int w = 0; w < 20000 && donec == 0; w++) begin
         @(posedge clk); #1;
         if (poke) start = (w >= 300 && w < 320);
      end
      start = 1'b0;
      repeat (4) @(posedge clk);
      #1;
      check("R6/R9 synced", int'(synced), int'(exp_s));
      check("R7/R8/R9 edge count", nrise, exp_e);
      check("R10 done width", donec, 1);
      check("R2 high phase width", hiw, half);
      check("R4 reset pulse cycles", rstc, p ? half : 0);
      check("R3 first frame bits", int'(frame), int'(32'hAC53_0000));
      check("R5 settle before first edge", int'(first_rise >= SETTLE_B + half), 1);
   endtask

   initial begin
      #1;
      check("R1 sck at reset", int'(sck), 0);
      check("R1 tgt_rst at reset", int'(tgt_rst), 0);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 mosi after reset", int'(mosi), 0);
      check("R1 done after reset", int'(done), 0);
      check("R1 synced after reset", int'(synced), 0);

      for (int i = 0; i < 7; i++) begin
         run_vec(VEC[i][21], int'(VEC[i][20:17]), int'(VEC[i][16:14]), VEC[i][13],
                 VEC[i][12], int'(VEC[i][11:0]), 1'b0);
      end

      // R10: status from the last run stays until a new start
      repeat (10) @(posedge clk);
      #1 check("R10 synced held", int'(synced), 1);

      // R11: extra start requests during a run change nothing
      run_vec(1'b0, 3, 5, 1'b1, 1'b1, 131, 1'b1);

      // R9 after a success: a no-device run clears synced
      run_vec(1'b0, 2, 2, 1'b0, 1'b0, 1055, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule